// File: doc/BRIEF.md
# Dual-Channel Keyboard Controller Host Register Block

This block sits between a CPU byte bus and two serial-device channels, a keyboard channel and an auxiliary (pointing device) channel. Each channel hands over received bytes through a valid/ready handshake. The block keeps one holding slot per source and a two-bit pending mask. The CPU sees both slots through one shared data register, and the keyboard slot always drains first. A second register returns status on a read and takes controller commands on a write. A mode byte enables or suppresses two level-sensitive interrupt lines, one per source.

A parameter selects between two address maps. The port map places the data register at `BASE` and the status/command register at `BASE+4`. The windowed map decodes a register index as `(addr - BASE) >> STRIDE` over a window of `8 << STRIDE` bytes. The controller understands two commands: one copies the mode byte into the keyboard slot, and the other makes the next data-register write load the mode byte. Any other data-register write is passed to the keyboard channel as a one-cycle strobe.

Top module: `kbc_host_regs`

## Requirements
- R1: After reset the pending mask is empty, the status byte reads 0x00, the mode byte is 0x01, both interrupt lines are low, both channel ready outputs are high, and a data read returns 0x00.
- R2: A channel byte is taken in the cycle where its valid and ready are both high. That source's ready output then stays low until a CPU data read drains its slot.
- R3: Status bit 0 (output full) is 1 exactly when at least one source is pending.
- R4: Status bit 5 (aux output full) is 1 only when the aux source is pending and the keyboard source is not. All other status bits read 0.
- R5: A CPU data read returns the keyboard byte if keyboard is pending, and otherwise the aux byte. It clears only the pending bit of the source it returned.
- R6: `irq_kbd` is a level that is high exactly when keyboard is pending, mode bit 0 (keyboard interrupt enable) is 1 and mode bit 4 (keyboard disable) is 0.
- R7: `irq_aux` is a level that is high exactly when aux is the only pending source and mode bit 1 (aux interrupt enable) is 1.
- R8: Command 0x20 written to the command register puts the current mode byte into the keyboard slot. If a keyboard channel byte is offered in the same cycle, the command takes the slot and the channel byte waits with ready low.
- R9: Command 0x60 arms a mode load, and the next data-register write then sets the mode byte and is not forwarded. Any other data-register write raises `kbd_out_valid` with that byte for exactly the following cycle.
- R10: In the port map (MMIO=0), the data register is at BASE and the status/command register is at BASE+4. Every other address reads 0xFF, and writes to other addresses change nothing.
- R11: In the windowed map (MMIO=1), index `(addr-BASE)>>STRIDE` is decoded within `8<<STRIDE` bytes from BASE. Index 0 is data and index 1 is status/command. Other indices and addresses outside the window read 0xFF, and writes to them are ignored.
- R12: A data read with nothing pending returns the byte delivered by the previous data read and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | CPU byte address |
| bus_rd | input | 1 | CPU read strobe (one access per cycle) |
| bus_wr | input | 1 | CPU write strobe |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | CPU read data for the current address |
| kbd_in_valid | input | 1 | Keyboard channel byte offered |
| kbd_in_data | input | 8 | Keyboard channel byte |
| kbd_in_ready | output | 1 | Keyboard slot can take a byte |
| aux_in_valid | input | 1 | Aux channel byte offered |
| aux_in_data | input | 8 | Aux channel byte |
| aux_in_ready | output | 1 | Aux slot can take a byte |
| kbd_out_valid | output | 1 | One-cycle strobe of a CPU byte for the keyboard channel |
| kbd_out_data | output | 8 | Byte for the keyboard channel |
| irq_kbd | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Aux interrupt level |

## Verification
Two cases can collide in one cycle. In the first, the mode-readback command arrives while the keyboard channel offers a byte to an empty slot. The bench drives both on the same edge, expects ready to stay low, reads the mode byte first, and then reads the channel byte once the handshake has completed. In the second, a data read drains the keyboard slot while aux is also pending. There the bench checks that aux survives, that the aux flag and aux interrupt come up only after that read, and that the next read returns the aux byte.

// File: rtl/kbc_host_regs.sv
module kbc_host_regs #(
  parameter bit                 MMIO     = 1'b0,
  parameter int unsigned        ADDR_W   = 12,
  parameter logic [ADDR_W-1:0]  BASE     = 'h060,
  parameter int unsigned        STRIDE   = 0,
  parameter logic [7:0]         MODE_RST = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              kbd_in_valid,
  input  logic [7:0]        kbd_in_data,
  output logic              kbd_in_ready,
  input  logic              aux_in_valid,
  input  logic [7:0]        aux_in_data,
  output logic              aux_in_ready,
  output logic              kbd_out_valid,
  output logic [7:0]        kbd_out_data,
  output logic              irq_kbd,
  output logic              irq_aux
);
  localparam int unsigned WIN     = 8 << STRIDE;
  localparam logic [7:0]  CMD_RDM = 8'h20;
  localparam logic [7:0]  CMD_WRM = 8'h60;

  logic [1:0] pend;
  logic [7:0] kbd_buf, aux_buf, last_byte, mode;
  logic       armed;
  logic       sel_data, sel_ctl;

  logic [ADDR_W-1:0] off;
  assign off = bus_addr - BASE;

  generate
    if (MMIO) begin : g_win
      logic [ADDR_W-1:0] idx;
      logic              in_win;
      assign idx      = off >> STRIDE;
      assign in_win   = (bus_addr >= BASE) && (32'(off) < WIN);
      assign sel_data = in_win && (idx == '0);
      assign sel_ctl  = in_win && (idx == ADDR_W'(1));
    end else begin : g_port
      assign sel_data = (bus_addr == BASE);
      assign sel_ctl  = (bus_addr == BASE + ADDR_W'(4));
    end
  endgenerate

  logic data_rd, data_wr, cmd_wr, rd_mode_cmd, kbd_take, aux_take;
  logic pop_kbd, pop_aux, aux_only;
  logic [7:0] head, status;

  assign data_rd     = bus_rd && sel_data;
  assign data_wr     = bus_wr && sel_data;
  assign cmd_wr      = bus_wr && sel_ctl;
  assign rd_mode_cmd = cmd_wr && (bus_wdata == CMD_RDM);

  assign kbd_in_ready = !pend[0] && !rd_mode_cmd;
  assign aux_in_ready = !pend[1];
  assign kbd_take     = kbd_in_valid && kbd_in_ready;
  assign aux_take     = aux_in_valid && aux_in_ready;

  assign aux_only = (pend == 2'b10);
  assign pop_kbd  = data_rd && pend[0];
  assign pop_aux  = data_rd && aux_only;

  assign head   = pend[0] ? kbd_buf : (pend[1] ? aux_buf : last_byte);
  assign status = {2'b00, aux_only, 4'b0000, |pend};

  assign bus_rdata = sel_data ? head : (sel_ctl ? status : 8'hFF);

  assign irq_kbd = pend[0] && mode[0] && !mode[4];
  assign irq_aux = aux_only && mode[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend          <= 2'b00;
      kbd_buf       <= 8'h00;
      aux_buf       <= 8'h00;
      last_byte     <= 8'h00;
      mode          <= MODE_RST;
      armed         <= 1'b0;
      kbd_out_valid <= 1'b0;
      kbd_out_data  <= 8'h00;
    end else begin
      pend[0] <= (pend[0] && !pop_kbd) || kbd_take || rd_mode_cmd;
      pend[1] <= (pend[1] && !pop_aux) || aux_take;
      if (rd_mode_cmd)   kbd_buf <= mode;
      else if (kbd_take) kbd_buf <= kbd_in_data;
      if (aux_take)      aux_buf <= aux_in_data;
      if (data_rd && (pend != 2'b00)) last_byte <= head;

      kbd_out_valid <= data_wr && !armed;
      if (data_wr && !armed) kbd_out_data <= bus_wdata;

      if (data_wr && armed) begin
        mode  <= bus_wdata;
        armed <= 1'b0;
      end else if (cmd_wr) begin
        armed <= (bus_wdata == CMD_WRM);
      end
    end
  end
endmodule

module kbc_host_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       data_rd,
  input logic       rd_mode_cmd,
  input logic [1:0] pend,
  input logic       kbd_in_valid,
  input logic       kbd_in_ready,
  input logic       aux_in_valid,
  input logic       aux_in_ready,
  input logic       kbd_out_valid,
  input logic       irq_kbd,
  input logic       irq_aux
);
  assert_kbd_slot_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!kbd_in_ready && !data_rd) |=> !kbd_in_ready);

  assert_aux_take_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_in_valid && aux_in_ready) |=> !aux_in_ready);

  assert_kbd_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && pend == 2'b11) |=> !aux_in_ready);

  assert_irq_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_aux |-> !irq_kbd);

  assert_irq_kbd_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_kbd) |-> ($past(kbd_in_valid && kbd_in_ready) || $past(rd_mode_cmd) || $past(bus_wr)));

  assert_rdmode_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode_cmd |=> !kbd_in_ready);

  assert_out_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_out_valid |-> $past(bus_wr));
endmodule

bind kbc_host_regs kbc_host_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .data_rd(data_rd),
  .rd_mode_cmd(rd_mode_cmd), .pend(pend),
  .kbd_in_valid(kbd_in_valid), .kbd_in_ready(kbd_in_ready),
  .aux_in_valid(aux_in_valid), .aux_in_ready(aux_in_ready),
  .kbd_out_valid(kbd_out_valid), .irq_kbd(irq_kbd), .irq_aux(irq_aux)
);

// File: tb/sim_kbc_host_regs.sv
`timescale 1ns/1ps
module sim_kbc_host_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [11:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  rd0, rd1;
  logic        k0v = 1'b0, a0v = 1'b0, k1v = 1'b0, a1v = 1'b0;
  logic [7:0]  k0d = '0, a0d = '0, k1d = '0, a1d = '0;
  logic        k0r, a0r, k1r, a1r;
  logic        o0v, o1v;
  logic [7:0]  o0d, o1d;
  logic        ik0, ia0, ik1, ia1;

  kbc_host_regs #(.MMIO(1'b0), .ADDR_W(12), .BASE(12'h060), .STRIDE(0)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rd0),
    .kbd_in_valid(k0v), .kbd_in_data(k0d), .kbd_in_ready(k0r),
    .aux_in_valid(a0v), .aux_in_data(a0d), .aux_in_ready(a0r),
    .kbd_out_valid(o0v), .kbd_out_data(o0d), .irq_kbd(ik0), .irq_aux(ia0));

  kbc_host_regs #(.MMIO(1'b1), .ADDR_W(12), .BASE(12'h100), .STRIDE(2)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rd1),
    .kbd_in_valid(k1v), .kbd_in_data(k1d), .kbd_in_ready(k1r),
    .aux_in_valid(a1v), .aux_in_data(a1d), .aux_in_ready(a1r),
    .kbd_out_valid(o1v), .kbd_out_data(o1d), .irq_kbd(ik1), .irq_aux(ia1));

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (bus_rd) begin
      if (exp_q.size() == 0) chk("scoreboard", 1, 0);
      else chk(tag_q.pop_front(), (bus_addr >= 12'h100) ? rd1 : rd0, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic send_kbd(input logic [7:0] d);
    @(negedge clk); k0v = 1'b1; k0d = d;
    @(negedge clk); k0v = 1'b0;
  endtask

  task automatic send_aux(input logic [7:0] d);
    @(negedge clk); a0v = 1'b1; a0d = d;
    @(negedge clk); a0v = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      chk("watchdog", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 irq_kbd", ik0, 0); chk("R1 irq_aux", ia0, 0);
    chk("R1 kbd ready", k0r, 1); chk("R1 aux ready", a0r, 1);
    rd(12'h064, 8'h00, "R1 status");
    rd(12'h060, 8'h00, "R1 empty data");
    wr(12'h064, 8'h20);
    rd(12'h064, 8'h01, "R8 status after readback");
    rd(12'h060, 8'h01, "R1 mode reset");

    send_kbd(8'h1C); #1;
    chk("R6 irq_kbd", ik0, 1); chk("R2 kbd ready low", k0r, 0);
    rd(12'h064, 8'h01, "R3 full");
    rd(12'h060, 8'h1C, "R5 kbd byte");
    #1 chk("R2 kbd ready again", k0r, 1);
    rd(12'h064, 8'h00, "R3 empty");
    rd(12'h060, 8'h1C, "R12 last byte");

    send_aux(8'hAA); #1;
    chk("R7 aux irq masked", ia0, 0);
    rd(12'h064, 8'h21, "R4 aux only");
    wr(12'h064, 8'h60); wr(12'h060, 8'h03); #1;
    chk("R7 aux irq", ia0, 1); chk("R9 mode write not forwarded", o0v, 0);
    rd(12'h060, 8'hAA, "R5 aux byte");
    #1 chk("R7 aux irq drop", ia0, 0);

    send_aux(8'h55); send_kbd(8'h33); #1;
    chk("R6 irq_kbd both", ik0, 1); chk("R7 aux not sole", ia0, 0);
    rd(12'h064, 8'h01, "R4 both pending");
    rd(12'h060, 8'h33, "R5 kbd first");
    #1 chk("R7 aux sole after drain", ia0, 1);
    rd(12'h064, 8'h21, "R4 aux remains");
    rd(12'h060, 8'h55, "R5 aux second");

    wr(12'h064, 8'h60); wr(12'h060, 8'h13);
    send_kbd(8'h44); #1;
    chk("R6 kbd disabled", ik0, 0);
    rd(12'h064, 8'h01, "R3 full disabled");
    rd(12'h060, 8'h44, "R5 kbd byte");

    wr(12'h060, 8'hED); #1;
    chk("R9 out valid", o0v, 1); chk("R9 out data", o0d, 8'hED);
    @(negedge clk); #1 chk("R9 out one cycle", o0v, 0);

    @(negedge clk);
    k0v = 1'b1; k0d = 8'h77; bus_addr = 12'h064; bus_wdata = 8'h20; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; #1;
    chk("R8 channel held", k0r, 0);
    rd(12'h060, 8'h13, "R8 mode wins");
    @(negedge clk); k0v = 1'b0;
    rd(12'h060, 8'h77, "R8 channel byte after");

    rd(12'h061, 8'hFF, "R10 hole");
    rd(12'h068, 8'hFF, "R10 hole");
    wr(12'h065, 8'h60); wr(12'h060, 8'h5A); #1;
    chk("R10 stray cmd ignored", o0v, 1); chk("R10 forwarded data", o0d, 8'h5A);
    wr(12'h064, 8'h20);
    rd(12'h060, 8'h13, "R10 mode unchanged");

    rd(12'h104, 8'h00, "R11 status idx1");
    rd(12'h108, 8'hFF, "R11 idx2");
    rd(12'h11C, 8'hFF, "R11 idx7");
    rd(12'h120, 8'hFF, "R11 outside");
    @(negedge clk); k1v = 1'b1; k1d = 8'h3A;
    @(negedge clk); k1v = 1'b0;
    rd(12'h107, 8'h01, "R11 status stride");
    rd(12'h103, 8'h3A, "R11 data stride");
    wr(12'h10C, 8'h60); wr(12'h101, 8'h9F); #1;
    chk("R11 idx3 write ignored", o1v, 1); chk("R11 forwarded", o1d, 8'h9F);
    chk("R11 port instance untouched", o0v, 0);
    wr(12'h105, 8'h20);
    rd(12'h100, 8'h01, "R11 mode unchanged");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule